// File: doc/BRIEF.md
# Strobed Input Handshake Channel

This block is one input channel of a parallel I/O port group running in strobed mode. A peripheral puts a byte on the eight port pins and pulses an active-low strobe. The channel captures the byte into a holding latch and raises a buffer-full flag, which tells the peripheral that the byte has been taken. It then asks for service on an interrupt line, if interrupts are enabled for this channel. The CPU side sees a read strobe plus a select line that the bus decoder drives while this port is addressed. The latch contents are always present on the read data output.

The interrupt enable is not a register of its own. It is one bit of port C that the bit set/reset command writes. Set/reset of bit 4 addresses the channel built for port A, and set/reset of bit 2 addresses the one built for port B. A mode selection pulse or a reset clears the enable, the buffer-full flag and the pending request. The strobe and read inputs are asynchronous, so they pass through a configurable synchronizer before their edges are detected. The pin data goes through a matching synchronizer so that it stays aligned with the strobe.

Top module: `strb_in_chan`

## Requirements
- R1: After reset, rd_data is 0 and ibf, intr and int_en are all 0.
- R2: Pins and strobe are seen two clocks late (two synchronizer stages). While the delayed strobe is low, the latch loads the delayed pin value on every clock. At all other times the latch holds its value, even when the pins change.
- R3: ibf goes to 1 while the delayed strobe is low. It returns to 0 only on the rising edge of the delayed rd_n while port_sel is 1, or on mode_set.
- R4: A command with bsr_valid=1 and bsr_bit equal to the enable index (4 for CHAN=port A, 2 for port B) sets int_en to the value of bsr_val. A command with any other bsr_bit leaves int_en unchanged.
- R5: The pending request is set on the rising edge of the delayed strobe when ibf and int_en are both 1. It is cleared on the falling edge of the delayed rd_n while port_sel is 1, so intr is already 0 while the read is still low.
- R6: intr equals the pending request ANDed with int_en. It is never 1 while int_en is 0, and it comes back if int_en is set again while the request is still pending.
- R7: mode_set clears int_en, ibf and the pending request on the next clock. The latch contents are kept.
- R8: A second strobe that arrives while ibf is still 1 overwrites the latch, and ibf stays 1.
- R9: Read strobes that occur while port_sel is 0 change neither ibf nor intr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_set | input | 1 | One-cycle pulse: a mode selection was written |
| pin_data | input | DATA_W | Port pins from the peripheral |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| rd_n | input | 1 | CPU read strobe, active low, asynchronous |
| port_sel | input | 1 | Bus decoder selects this port; hold it through the read |
| bsr_valid | input | 1 | One-cycle pulse: a port C bit set/reset command |
| bsr_bit | input | 3 | Port C bit index of the command |
| bsr_val | input | 1 | 1 = set, 0 = reset |
| rd_data | output | DATA_W | Contents of the input latch |
| ibf | output | 1 | Buffer-full acknowledge to the peripheral |
| intr | output | 1 | Interrupt request to the CPU |
| int_en | output | 1 | Current interrupt enable bit |

## Verification
The bench sends single strobes with interrupts disabled. These show that capture and buffer-full work without any interrupt. It then changes the pins with no strobe, which shows that the latch is not transparent. Back-to-back strobes with no read in between show that the newest byte overwrites the latch. Reads with the select line low are kept apart from selected reads, so an unselected read cannot be mistaken for one that clears ibf. Toggling the enable through the matching bit and through a foreign bit (2 on a port A channel) shows the gating and the bit decode. A mode pulse while a request is pending shows that the flags are cleared but the data survives.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int PC_W     = 8;
    localparam int PC_IDX_W = $clog2(PC_W);

    typedef enum logic {
        CH_PORT_A = 1'b0,
        CH_PORT_B = 1'b1
    } chan_e;

    // synchronized control inputs, both idle high
    typedef struct packed {
        logic stb_n;
        logic rd_n;
    } ctl_t;

    // per-cycle events derived from synchronized controls
    typedef struct packed {
        logic stb_low;
        logic stb_rise;
        logic rd_fall;
        logic rd_rise;
    } evt_t;

    // port C bit whose set/reset writes the channel's interrupt enable
    function automatic logic [PC_IDX_W-1:0] enable_bit(chan_e ch);
        return (ch == CH_PORT_A) ? PC_IDX_W'(4) : PC_IDX_W'(2);
    endfunction

    function automatic evt_t decode_evt(ctl_t now, ctl_t prev, logic sel);
        evt_t e;
        e.stb_low  = !now.stb_n;
        e.stb_rise = !prev.stb_n && now.stb_n;
        e.rd_fall  = sel && prev.rd_n && !now.rd_n;
        e.rd_rise  = sel && !prev.rd_n && now.rd_n;
        return e;
    endfunction

endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sic_capture.sv
module sic_capture import sic_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_set,
    input  evt_t              evt,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] latch_q,
    output logic              full_q
);

    // level-loaded latch: follows the pins while the strobe is held low
    always_ff @(posedge clk) begin
        if (rst)              latch_q <= '0;
        else if (evt.stb_low) latch_q <= din;
    end

    // a new load outranks a clearing read in the same cycle
    always_ff @(posedge clk) begin
        if (rst || mode_set)  full_q <= 1'b0;
        else if (evt.stb_low) full_q <= 1'b1;
        else if (evt.rd_rise) full_q <= 1'b0;
    end

endmodule

// File: rtl/sic_irq.sv
module sic_irq import sic_pkg::*; #(
    parameter logic [PC_IDX_W-1:0] EN_BIT = PC_IDX_W'(4)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_set,
    input  evt_t                evt,
    input  logic                full,
    input  logic                bsr_valid,
    input  logic [PC_IDX_W-1:0] bsr_bit,
    input  logic                bsr_val,
    output logic                en_q,
    output logic                req_out
);

    logic hit;
    logic pend_q;

    assign hit = bsr_valid && (bsr_bit == EN_BIT);

    always_ff @(posedge clk) begin
        if (rst || mode_set) en_q <= 1'b0;
        else if (hit)        en_q <= bsr_val;
    end

    always_ff @(posedge clk) begin
        if (rst || mode_set)                     pend_q <= 1'b0;
        else if (evt.stb_rise && full && en_q)   pend_q <= 1'b1;
        else if (evt.rd_fall)                    pend_q <= 1'b0;
    end

    assign req_out = pend_q && en_q;

endmodule

// File: rtl/strb_in_chan.sv
module strb_in_chan import sic_pkg::*; #(
    parameter chan_e CHAN        = CH_PORT_A,
    parameter int    DATA_W      = 8,
    parameter int    SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_set,
    input  logic [DATA_W-1:0]   pin_data,
    input  logic                stb_n,
    input  logic                rd_n,
    input  logic                port_sel,
    input  logic                bsr_valid,
    input  logic [PC_IDX_W-1:0] bsr_bit,
    input  logic                bsr_val,
    output logic [DATA_W-1:0]   rd_data,
    output logic                ibf,
    output logic                intr,
    output logic                int_en
);

    localparam logic [PC_IDX_W-1:0] EN_BIT = enable_bit(CHAN);
    localparam int                  CTL_W  = $bits(ctl_t);

    logic [CTL_W-1:0]  ctl_raw;
    logic [DATA_W-1:0] data_s;
    ctl_t              ctl_s;
    ctl_t              ctl_prev;
    evt_t              evt;

    sic_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .d   ({stb_n, rd_n}),
        .q   (ctl_raw)
    );

    sic_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_data),
        .q   (data_s)
    );

    assign ctl_s = ctl_t'(ctl_raw);

    always_ff @(posedge clk) begin
        if (rst) ctl_prev <= '1;
        else     ctl_prev <= ctl_s;
    end

    assign evt = decode_evt(ctl_s, ctl_prev, port_sel);

    sic_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .mode_set (mode_set),
        .evt      (evt),
        .din      (data_s),
        .latch_q  (rd_data),
        .full_q   (ibf)
    );

    sic_irq #(.EN_BIT(EN_BIT)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .mode_set  (mode_set),
        .evt       (evt),
        .full      (ibf),
        .bsr_valid (bsr_valid),
        .bsr_bit   (bsr_bit),
        .bsr_val   (bsr_val),
        .en_q      (int_en),
        .req_out   (intr)
    );

endmodule

// File: rtl/sic_chk.sv
module sic_chk import sic_pkg::*; #(
    parameter logic [PC_IDX_W-1:0] EN_BIT = PC_IDX_W'(4)
) (
    input logic                clk,
    input logic                rst,
    input logic                mode_set,
    input logic                port_sel,
    input logic                bsr_valid,
    input logic [PC_IDX_W-1:0] bsr_bit,
    input logic                bsr_val,
    input logic                ibf,
    input logic                intr,
    input logic                int_en
);

    assert_intr_gated_R6: assert property (@(posedge clk) disable iff (rst)
        intr |-> int_en);

    assert_mode_clears_R7: assert property (@(posedge clk) disable iff (rst)
        mode_set |=> (!ibf && !intr && !int_en));

    assert_ibf_drop_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ibf) |-> ($past(mode_set) || $past(port_sel)));

    assert_bsr_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (bsr_valid && bsr_bit == EN_BIT && !mode_set) |=> (int_en == $past(bsr_val)));

    assert_bsr_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (bsr_valid && bsr_bit != EN_BIT && !mode_set) |=> $stable(int_en));

endmodule

bind strb_in_chan sic_chk #(.EN_BIT(EN_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_set  (mode_set),
    .port_sel  (port_sel),
    .bsr_valid (bsr_valid),
    .bsr_bit   (bsr_bit),
    .bsr_val   (bsr_val),
    .ibf       (ibf),
    .intr      (intr),
    .int_en    (int_en)
);

// File: tb/strb_in_chan_tb_top.sv
module strb_in_chan_tb_top;
    import sic_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_set = 1'b0;
    logic [7:0] pin_data = 8'h00;
    logic       stb_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       port_sel = 1'b0;
    logic       bsr_valid = 1'b0;
    logic [2:0] bsr_bit = 3'd0;
    logic       bsr_val = 1'b0;
    logic [7:0] rd_data;
    logic       ibf, intr, int_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strb_in_chan #(.CHAN(CH_PORT_A), .DATA_W(8), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .mode_set(mode_set), .pin_data(pin_data),
        .stb_n(stb_n), .rd_n(rd_n), .port_sel(port_sel),
        .bsr_valid(bsr_valid), .bsr_bit(bsr_bit), .bsr_val(bsr_val),
        .rd_data(rd_data), .ibf(ibf), .intr(intr), .int_en(int_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // behavioural reference: histories of sampled inputs, two-clock view
    bit         q_s[$];
    bit         q_r[$];
    logic [7:0] q_d[$];
    logic [7:0] m_lat = 8'h00;
    bit         m_ibf = 0, m_irq = 0, m_inte = 0;
    bit         s, ps, r, pr, n_ibf, n_irq, n_inte;

    always @(posedge clk) begin
        if (rst) begin
            q_s = '{1, 1, 1, 1};
            q_r = '{1, 1, 1, 1};
            q_d = '{8'h00, 8'h00, 8'h00, 8'h00};
            m_lat = 8'h00; m_ibf = 0; m_irq = 0; m_inte = 0;
        end else begin
            q_s.push_front(stb_n);    void'(q_s.pop_back());
            q_r.push_front(rd_n);     void'(q_r.pop_back());
            q_d.push_front(pin_data); void'(q_d.pop_back());
            s = q_s[2]; ps = q_s[3]; r = q_r[2]; pr = q_r[3];
            if (!s) m_lat = q_d[2];
            if (mode_set) begin
                n_inte = 0; n_ibf = 0; n_irq = 0;
            end else begin
                n_inte = (bsr_valid && bsr_bit == 3'd4) ? bsr_val : m_inte;
                if (!s)                         n_ibf = 1;
                else if (!pr && r && port_sel)  n_ibf = 0;
                else                            n_ibf = m_ibf;
                if (!ps && s && m_ibf && m_inte) n_irq = 1;
                else if (pr && !r && port_sel)   n_irq = 0;
                else                             n_irq = m_irq;
            end
            m_inte = n_inte; m_ibf = n_ibf; m_irq = n_irq;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 latch", {24'd0, rd_data}, {24'd0, m_lat});
            chk("R3 ibf", {31'd0, ibf}, {31'd0, m_ibf});
            chk("R5 intr", {31'd0, intr}, {31'd0, (m_irq & m_inte)});
            chk("R4 int_en", {31'd0, int_en}, {31'd0, m_inte});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] v, input int lo);
        @(negedge clk);
        pin_data = v;
        stb_n = 1'b0;
        repeat (lo) @(negedge clk);
        stb_n = 1'b1;
    endtask

    task automatic rd_cycle(input logic sel, input int lo);
        @(negedge clk);
        port_sel = sel;
        rd_n = 1'b0;
        repeat (lo) @(negedge clk);
        rd_n = 1'b1;
        idle(4);
        port_sel = 1'b0;
    endtask

    task automatic bsr(input logic [2:0] b, input logic v);
        @(negedge clk);
        bsr_valid = 1'b1; bsr_bit = b; bsr_val = v;
        @(negedge clk);
        bsr_valid = 1'b0;
    endtask

    task automatic mode_pulse();
        @(negedge clk);
        mode_set = 1'b1;
        @(negedge clk);
        mode_set = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 rd_data", {24'd0, rd_data}, 32'h0);
        chk("R1 ibf", {31'd0, ibf}, 32'h0);
        chk("R1 intr", {31'd0, intr}, 32'h0);
        chk("R1 int_en", {31'd0, int_en}, 32'h0);

        // capture with interrupts disabled
        strobe(8'hA5, 3);
        idle(5);
        chk("R2 captured", {24'd0, rd_data}, 32'hA5);
        chk("R3 ibf set", {31'd0, ibf}, 32'h1);
        chk("R6 no intr when disabled", {31'd0, intr}, 32'h0);

        // pins move with no strobe: latch holds
        @(negedge clk); pin_data = 8'h3C;
        idle(5);
        chk("R2 hold", {24'd0, rd_data}, 32'hA5);

        // unselected read is ignored
        rd_cycle(1'b0, 3);
        chk("R9 ibf kept", {31'd0, ibf}, 32'h1);

        // selected read clears buffer-full
        rd_cycle(1'b1, 3);
        chk("R3 ibf cleared", {31'd0, ibf}, 32'h0);

        // enable decode
        bsr(3'd5, 1'b1);
        idle(1);
        chk("R4 foreign bit", {31'd0, int_en}, 32'h0);
        bsr(3'd4, 1'b1);
        idle(1);
        chk("R4 enable set", {31'd0, int_en}, 32'h1);

        // interrupt on strobe end, cleared at read start
        strobe(8'h5A, 2);
        idle(5);
        chk("R5 intr raised", {31'd0, intr}, 32'h1);
        @(negedge clk); port_sel = 1'b1; rd_n = 1'b0;
        idle(4);
        chk("R5 intr dropped at read start", {31'd0, intr}, 32'h0);
        chk("R3 ibf still set during read", {31'd0, ibf}, 32'h1);
        rd_n = 1'b1;
        idle(4);
        port_sel = 1'b0;
        chk("R3 ibf cleared after read", {31'd0, ibf}, 32'h0);

        // overwrite while full
        strobe(8'h11, 2);
        idle(5);
        strobe(8'h22, 2);
        idle(5);
        chk("R8 overwrite", {24'd0, rd_data}, 32'h22);
        chk("R8 ibf stays", {31'd0, ibf}, 32'h1);
        chk("R5 intr pending", {31'd0, intr}, 32'h1);

        // gating by enable
        bsr(3'd4, 1'b0);
        idle(1);
        chk("R6 gated off", {31'd0, intr}, 32'h0);
        bsr(3'd2, 1'b1);
        idle(1);
        chk("R4 port B bit ignored", {31'd0, int_en}, 32'h0);
        bsr(3'd4, 1'b1);
        idle(1);
        chk("R6 request returns", {31'd0, intr}, 32'h1);

        // mode selection
        mode_pulse();
        idle(1);
        chk("R7 int_en", {31'd0, int_en}, 32'h0);
        chk("R7 ibf", {31'd0, ibf}, 32'h0);
        chk("R7 intr", {31'd0, intr}, 32'h0);
        chk("R7 data kept", {24'd0, rd_data}, 32'h22);

        strobe(8'hC3, 4);
        idle(5);
        chk("R3 ibf after mode", {31'd0, ibf}, 32'h1);
        chk("R6 intr off after mode", {31'd0, intr}, 32'h0);
        chk("R2 new data", {24'd0, rd_data}, 32'hC3);

        idle(3);
        report();
        $finish;
    end

endmodule